// File: doc/BRIEF.md
# Second-Order Mismatch-Shaping Split Node

This block is one node of a binary splitting tree used in front of a bank of equal unit elements. It takes an integer sample `x` in the range 0 to 2^L, where L is the layer of the node, and hands its two children the values `(x+s)/2` and `(x-s)/2`. The steering value `s` always has the same parity as `x`, so both halves are whole numbers. Both halves also stay inside the range 0 to 2^(L-1) that a child of layer L-1 can accept. Over time the node chooses `s` so that any gain mismatch between the two children turns into error that is pushed toward high frequencies with a second-order slope.

`s` comes from a small integer loop that has no signal input. Two signed integrators feed a quantizer whose input is their sum times one quarter. The quantizer steps by 2. It rounds to the nearest even integer when `x` is even (midtread mode) and to the nearest odd integer when `x` is odd (midrise mode). A clamp follows the quantizer. The clamped `s` is fed back into both integrators on every clock. Both state registers saturate at their signed limits.

The quantizer has one internal decision between its two candidates. PICK_LO takes the lower candidate and PICK_HI takes the upper one. The choice goes to PICK_HI when the sum is strictly nearer the upper candidate, or on a tie whose lower candidate is negative. Otherwise it goes to PICK_LO.

Top module: `sos_split_node`

## Requirements
- R1: On every cycle `out_hi + out_lo` equals `x_in`.
- R2: The steering value `out_hi - out_lo` has the same parity as bit 0 of `x_in`.
- R3: For `x_in` in 0..2^L, both outputs lie in 0..2^(L-1). With L = 3 that is 0..4.
- R4: Before clamping, `s` is the integer with the parity of `x_in[0]` that is nearest to `(v1+v2)/4`. On an equal-distance tie, the candidate of smaller magnitude wins. When the tie is between -1 and +1, the result is +1.
- R5: The clamp limits `s` to ±min(`x_in`, 2^L - `x_in`). So `x_in` = 0 gives outputs 0/0, and `x_in` = 2^L gives 2^(L-1) on both outputs.
- R6: On each clock, v1 becomes v1 - s. Then v2 becomes v2 + (new v1) - s. Both updates use the clamped s.
- R7: Each state register saturates at the bounds of a STW-bit signed value: -128..127 by default.
- R8: Reset clears both integrators to 0. Directly after reset an odd `x_in` therefore yields `s` = +1 (for example 5 gives 3/2), and an even `x_in` yields `s` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; loop state advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both integrators |
| x_in | input | LAYER+1 | Node input sample, 0..2^LAYER |
| out_hi | output | LAYER | Upper child value (x+s)/2 |
| out_lo | output | LAYER | Lower child value (x-s)/2 |

## Verification
The bench first targets rounding ties. These include the ±1 tie at a zero sum in midrise mode and the ties at odd multiples of four in midtread mode. A quantizer that resolved these ties away from zero, or toward -1, would put the outputs on the wrong side by one count.

It then drives the endpoints 0 and 2^L, where the clamp must force `s` to zero. A clamp bound off by one there would give a child a value of -1 or 2^(L-1)+1.

A run that holds `x_in` at 0 after a nonzero step lets v2 ramp into its negative limit. A register that wrapped instead of saturating would then steer with the wrong sign for many cycles.

Long random runs compare every output with an independent integer model of the loop.

// File: rtl/sos_pkg.sv
package sos_pkg;
    typedef enum logic {Q_MIDTREAD, Q_MIDRISE} qmode_e;
    typedef enum logic {PICK_LO, PICK_HI} pick_e;
endpackage

// File: rtl/sos_parity_quant.sv
module sos_parity_quant
    import sos_pkg::*;
#(
    parameter int STW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [STW:0]   sum_i,
    input  logic                  par_i,
    output logic signed [STW-1:0] s_o
);
    localparam int SW = STW + 2;

    logic signed [SW-1:0] sum_w, fl, lo, hi, dlo, q;
    qmode_e mode;
    pick_e  pick;

    always_comb begin
        sum_w = SW'(sum_i);
        fl    = sum_w >>> 2;
        mode  = par_i ? Q_MIDRISE : Q_MIDTREAD;
        unique case (mode)
            Q_MIDTREAD: lo = fl[0] ? fl - SW'(1) : fl;
            Q_MIDRISE:  lo = fl[0] ? fl : fl - SW'(1);
        endcase
        hi  = lo + SW'(2);
        dlo = sum_w - (lo <<< 2);
        if (dlo < SW'(4))
            pick = PICK_LO;
        else if (dlo > SW'(4))
            pick = PICK_HI;
        else
            pick = lo[SW-1] ? PICK_HI : PICK_LO;
        unique case (pick)
            PICK_LO: q = lo;
            PICK_HI: q = hi;
        endcase
        s_o = q[STW-1:0];
    end

    // R4
    quant_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q <<< 2) - sum_w <= SW'(4)) && (sum_w - (q <<< 2) <= SW'(4)) && (q[0] == par_i));
endmodule

// File: rtl/sos_limiter.sv
module sos_limiter #(
    parameter int LAYER = 3,
    parameter int STW   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LAYER:0]        x_i,
    input  logic signed [STW-1:0] s_raw_i,
    output logic signed [STW-1:0] s_o,
    output logic [LAYER-1:0]      hi_o,
    output logic [LAYER-1:0]      lo_o
);
    localparam int XW   = LAYER + 1;
    localparam int WW   = STW + 2;
    localparam int FULL = 2 ** LAYER;
    localparam int HALF = 2 ** (LAYER - 1);

    logic [XW-1:0]        comp, bound;
    logic signed [STW-1:0] bnd_s;
    logic signed [WW-1:0]  xw, sw, hw, lw;

    always_comb begin
        comp  = XW'(FULL) - x_i;
        bound = (x_i < comp) ? x_i : comp;
        bnd_s = $signed(STW'(bound));
        if (s_raw_i > bnd_s)
            s_o = bnd_s;
        else if (s_raw_i < -bnd_s)
            s_o = -bnd_s;
        else
            s_o = s_raw_i;
        xw   = $signed(WW'(x_i));
        sw   = WW'(s_o);
        hw   = (xw + sw) >>> 1;
        lw   = (xw - sw) >>> 1;
        hi_o = hw[LAYER-1:0];
        lo_o = lw[LAYER-1:0];
    end

    // R2
    parity_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_o[0] == x_i[0]);

    // R3
    child_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i <= XW'(FULL)) |-> (hw >= 0 && hw <= HALF && lw >= 0 && lw <= HALF));
endmodule

// File: rtl/sos_loop_state.sv
module sos_loop_state #(
    parameter int STW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [STW-1:0] s_i,
    output logic signed [STW-1:0] v1_o,
    output logic signed [STW-1:0] v2_o
);
    localparam int WW = STW + 2;
    localparam logic signed [WW-1:0] MAXW = WW'((2 ** (STW - 1)) - 1);
    localparam logic signed [WW-1:0] MINW = -WW'(2 ** (STW - 1));

    logic signed [WW-1:0]  v1_w, v2_w;
    logic signed [STW-1:0] v1_n, v2_n;

    always_comb begin
        v1_w = WW'(v1_o) - WW'(s_i);
        if (v1_w > MAXW)      v1_n = MAXW[STW-1:0];
        else if (v1_w < MINW) v1_n = MINW[STW-1:0];
        else                  v1_n = v1_w[STW-1:0];
        v2_w = WW'(v2_o) + WW'(v1_n) - WW'(s_i);
        if (v2_w > MAXW)      v2_n = MAXW[STW-1:0];
        else if (v2_w < MINW) v2_n = MINW[STW-1:0];
        else                  v2_n = v2_w[STW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_o <= '0;
            v2_o <= '0;
        end else begin
            v1_o <= v1_n;
            v2_o <= v2_n;
        end
    end

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(v2_o) == MINW[STW-1:0] && $past(v1_o) <= 0 && $past(s_i) >= 0)
            |-> (v2_o == MINW[STW-1:0]));
endmodule

// File: rtl/sos_split_node.sv
module sos_split_node #(
    parameter int LAYER = 3,
    parameter int STW   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAYER:0]   x_in,
    output logic [LAYER-1:0] out_hi,
    output logic [LAYER-1:0] out_lo
);
    logic signed [STW-1:0] v1, v2, s_raw, s_lim;
    logic signed [STW:0]   sum;

    always_comb sum = $signed({v1[STW-1], v1}) + $signed({v2[STW-1], v2});

    sos_parity_quant #(.STW(STW)) u_quant (
        .clk(clk), .rst_n(rst_n), .sum_i(sum), .par_i(x_in[0]), .s_o(s_raw)
    );

    sos_limiter #(.LAYER(LAYER), .STW(STW)) u_limit (
        .clk(clk), .rst_n(rst_n), .x_i(x_in), .s_raw_i(s_raw),
        .s_o(s_lim), .hi_o(out_hi), .lo_o(out_lo)
    );

    sos_loop_state #(.STW(STW)) u_state (
        .clk(clk), .rst_n(rst_n), .s_i(s_lim), .v1_o(v1), .v2_o(v2)
    );

    // R1
    sum_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, out_hi} + {1'b0, out_lo}) == x_in);
endmodule

// File: tb/tb_sos_split_node.sv
module tb_sos_split_node;
    localparam int LAYER = 3;
    localparam int FULL  = 2 ** LAYER;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LAYER:0]   x_in = '0;
    logic [LAYER-1:0] out_hi, out_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int m_v1 = 0;
    int m_v2 = 0;

    sos_split_node #(.LAYER(LAYER), .STW(8)) dut (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .out_hi(out_hi), .out_lo(out_lo)
    );

    always #5 clk = ~clk;

    function automatic int sat8(int v);
        return (v > 127) ? 127 : ((v < -128) ? -128 : v);
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int quant(int sum, int p);
        int best = 0;
        int bd = 100000;
        for (int c = -80; c <= 80; c++) begin
            if ((c & 1) == p) begin
                int d = iabs(4 * c - sum);
                if (d < bd || (d == bd && (iabs(c) < iabs(best) ||
                                           (iabs(c) == iabs(best) && c > best)))) begin
                    best = c;
                    bd = d;
                end
            end
        end
        return best;
    endfunction

    function automatic int limit(int s, int x);
        int m = (x < FULL - x) ? x : FULL - x;
        return (s > m) ? m : ((s < -m) ? -m : s);
    endfunction

    task automatic step(input int x, input string req);
        int s, eh, el, n1;
        @(negedge clk);
        x_in = x[LAYER:0];
        #2;
        s  = limit(quant(m_v1 + m_v2, x & 1), x);
        eh = (x + s) / 2;
        el = (x - s) / 2;
        checks++;
        if (int'(out_hi) != eh || int'(out_lo) != el) begin
            errors++;
            $display("FAIL %s x=%0d actual hi/lo=%0d/%0d expected %0d/%0d",
                     req, x, out_hi, out_lo, eh, el);
        end
        if (rst_n) begin
            n1   = sat8(m_v1 - s);
            m_v2 = sat8(m_v2 + n1 - s);
            m_v1 = n1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_v1 = 0;
        m_v2 = 0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        // R8: reset state, outputs during reset
        step(5, "R8");
        step(2, "R8");
        @(negedge clk);
        rst_n = 1'b1;
        step(5, "R8");
        step(5, "R4");
        step(5, "R4");
        step(4, "R4");
        // R5: endpoints force s to zero
        step(FULL, "R5");
        step(0, "R5");
        step(FULL, "R5");
        // R7: ramp v2 into its negative limit
        do_reset();
        @(negedge clk);
        rst_n = 1'b1;
        step(5, "R7");
        for (int i = 0; i < 300; i++) step(0, "R7");
        for (int i = 0; i < 200; i++) step(int'($urandom_range(0, FULL)), "R7");
        // R6: long random run against the model
        for (int i = 0; i < 3000; i++) step(int'($urandom_range(0, FULL)), "R6");
        // R2 / R3 / R1 directed patterns
        for (int i = 0; i < 100; i++) step(1, "R2");
        for (int i = 0; i < 100; i++) step(FULL - 1, "R3");
        for (int i = 0; i < 100; i++) step((i % 2 == 0) ? 3 : 4, "R1");
        for (int i = 0; i < 100; i++) step(FULL / 2, "R4");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #5_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule